// File: doc/BRIEF.md
# Stochastic-Rate and Latency Spike Encoder

This block turns a small bank of unsigned 8-bit intensities into binary spike trains, one output bit per channel, for a spiking neural network. Each pulse of the timestep strobe is one algorithmic step. In the cycle after each strobe the block sets one spike bit per channel, and the bits are low in every other cycle.

Two codes are available, chosen by a mode input. The stochastic rate code compares each stored value with a fresh pseudo-random byte on every step, so the long-run spike density follows the value. The latency code emits a single spike per channel per presentation, and larger values fire sooner. A presentation-start pulse restarts the latency window. Values are written one channel at a time through an indexed load port. The random source is a 16-bit maximal-length shift register with a loadable seed that can never become zero.

Top module: `spike_encoder`

## Requirements
- R1: After reset every spike bit is 0, all stored values are 0, the step count is 0 and the random register holds the SEED parameter (default 16'hACE1).
- R2: The random register advances once per step with next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. Channel c draws bits [15:8] of s rotated left by 2*c, where s is the state before the advance. In rate mode (mode = 0), the spike for that step is 1 exactly when the draw is strictly less than the channel's value.
- R3: A seed load replaces the random state in the next cycle and takes priority over an advance. A seed of 0 is stored as 16'h0001. The state is never 0.
- R4: A channel whose value is 0 never spikes in either mode.
- R5: In latency mode (mode = 1), a channel with a nonzero value v spikes on the step whose index after presentation start is 255 - v. Index 0 is the first step after the start. It spikes only once per presentation.
- R6: Presentation start clears the step count and the fired flags and forces all spike bits to 0. It wins over a step strobe in the same cycle, although that strobe still advances the random register.
- R7: Spike bits are 1 only in the cycle right after a step strobe.
- R8: A load with index i writes only channel i. Its new value takes effect from the next step.
- R9: Over 65535 consecutive rate-mode steps, a channel with value v > 0 spikes exactly 256*v - 1 times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one channel value |
| ld_idx | input | $clog2(NCH) | Channel written by a load |
| ld_val | input | 8 | Value written by a load |
| seed_ld | input | 1 | Load the random seed |
| seed_val | input | 16 | Seed value (0 is stored as 1) |
| mode | input | 1 | 0 = stochastic rate, 1 = first-spike latency |
| step | input | 1 | Timestep strobe |
| start | input | 1 | Presentation start |
| spikes | output | NCH | One spike bit per channel |

## Verification
Any fault in the random register shows up at the ports within a step or two, because every channel compares against a rotated copy of the same state. A wrong tap or a wrong rotation therefore changes the spike pattern almost at once, and a full-period count detects any loss of maximal length. A step counter that is off by one, or a missing fired flag, moves or repeats a latency spike within a single 256-step window. A stale value bank or a wrong load decode changes the first spike on the channel concerned.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam int VAL_W  = 8;
  localparam int RND_W  = 16;
  localparam int CNT_W  = VAL_W + 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(1 << VAL_W);

  // Fibonacci step, taps 16,14,13,11
  function automatic logic [RND_W-1:0] lfsr_next(input logic [RND_W-1:0] s);
    return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Rotate state left by 2*c, keep the upper byte
  function automatic logic [VAL_W-1:0] chan_draw(input logic [RND_W-1:0] s, input int c);
    logic [2*RND_W-1:0] dbl;
    logic [2*RND_W-1:0] sh;
    dbl = {s, s};
    sh  = dbl >> (RND_W - ((2 * c) % RND_W));
    return sh[RND_W-1 -: VAL_W];
  endfunction

  // Latency slot: fires when step index equals max - v
  function automatic logic ttfs_hit(input logic [CNT_W-1:0] cnt, input logic [VAL_W-1:0] v);
    return (v != '0) && (cnt == {1'b0, ~v});
  endfunction
endpackage

// File: rtl/spk_lfsr.sv
module spk_lfsr
  import spk_pkg::*;
#(
  parameter logic [RND_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             load,
  input  logic [RND_W-1:0] seed,
  output logic [RND_W-1:0] state
);
  logic [RND_W-1:0] safe_seed;
  assign safe_seed = (seed == '0) ? RND_W'(1) : seed;

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= (SEED == '0) ? RND_W'(1) : SEED;
    else if (load)    state <= safe_seed;
    else if (advance) state <= lfsr_next(state);
  end
endmodule

// File: rtl/spk_step_timer.sv
module spk_step_timer
  import spk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  logic at_end;
  assign at_end = (cnt == CNT_END);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (start)           cnt <= '0;
    else if (step && !at_end) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spk_channel.sv
module spk_channel
  import spk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic [VAL_W-1:0] ld_val,
  input  logic             start,
  input  logic             step,
  input  logic             mode,
  input  logic [VAL_W-1:0] draw,
  input  logic [CNT_W-1:0] cnt,
  output logic             spike,
  output logic             fired,
  output logic             nonzero
);
  logic [VAL_W-1:0] val_q;
  logic rate_hit;
  logic lat_hit;

  assign rate_hit = (draw < val_q);
  assign lat_hit  = ttfs_hit(cnt, val_q) && !fired;
  assign nonzero  = (val_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      fired <= 1'b0;
      spike <= 1'b0;
    end else begin
      if (ld_we) val_q <= ld_val;
      if (start) begin
        fired <= 1'b0;
        spike <= 1'b0;
      end else if (step) begin
        if (mode) begin
          spike <= lat_hit;
          if (lat_hit) fired <= 1'b1;
        end else begin
          spike <= rate_hit;
        end
      end else begin
        spike <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spike_encoder.sv
module spike_encoder
  import spk_pkg::*;
#(
  parameter int NCH = 4,
  parameter logic [RND_W-1:0] SEED = 16'hACE1,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IW-1:0]    ld_idx,
  input  logic [VAL_W-1:0] ld_val,
  input  logic             seed_ld,
  input  logic [RND_W-1:0] seed_val,
  input  logic             mode,
  input  logic             step,
  input  logic             start,
  output logic [NCH-1:0]   spikes
);
  logic [RND_W-1:0] lfsr_q;
  logic [CNT_W-1:0] step_cnt;
  logic [NCH-1:0]   fired_q;
  logic [NCH-1:0]   nz_mask;
  logic             rnd_advance;

  assign rnd_advance = step && !seed_ld;

  spk_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .advance(rnd_advance),
    .load(seed_ld), .seed(seed_val), .state(lfsr_q)
  );

  spk_step_timer u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .cnt(step_cnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [VAL_W-1:0] draw_c;
    logic             we_c;
    assign draw_c = chan_draw(lfsr_q, c);
    assign we_c   = ld_en && (ld_idx == IW'(c));
    spk_channel u_ch (
      .clk(clk), .rst_n(rst_n), .ld_we(we_c), .ld_val(ld_val),
      .start(start), .step(step), .mode(mode), .draw(draw_c),
      .cnt(step_cnt), .spike(spikes[c]), .fired(fired_q[c]),
      .nonzero(nz_mask[c])
    );
  end
endmodule

// File: rtl/spike_encoder_chk.sv
module spike_encoder_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           step,
  input logic           start,
  input logic           seed_ld,
  input logic           mode,
  input logic [NCH-1:0] spikes,
  input logic [15:0]    lfsr_q,
  input logic [NCH-1:0] fired_q,
  input logic [NCH-1:0] nz_mask
);
  // R7
  spike_only_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(step) |-> (spikes == '0));

  // R6
  start_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (spikes == '0));

  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  // R2
  lfsr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !seed_ld) |=> (lfsr_q != $past(lfsr_q)));

  // R5
  single_latency_spike_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step) && !$past(start) && $past(mode)) |-> ((spikes & $past(fired_q)) == '0));

  // R4
  zero_value_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spikes & ~$past(nz_mask)) == '0);
endmodule

bind spike_encoder spike_encoder_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .start(start), .seed_ld(seed_ld),
  .mode(mode), .spikes(spikes), .lfsr_q(lfsr_q), .fired_q(fired_q),
  .nz_mask(nz_mask)
);

// File: tb/spike_encoder_bench.sv
module spike_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int WD_LIMIT = 190000;

  logic clk = 0;
  logic rst_n = 0;
  logic ld_en = 0;
  logic [1:0] ld_idx = 0;
  logic [7:0] ld_val = 0;
  logic seed_ld = 0;
  logic [15:0] seed_val = 0;
  logic mode = 0;
  logic step = 0;
  logic start = 0;
  logic [NCH-1:0] spikes;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench model
  logic [15:0] m_rnd;
  logic [7:0]  m_val [NCH];
  logic [NCH-1:0] m_fired;
  int m_cnt;
  int first_at [NCH];
  int n_fire [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  spike_encoder #(.NCH(NCH)) u_spike_encoder (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val),
    .seed_ld(seed_ld), .seed_val(seed_val), .mode(mode), .step(step),
    .start(start), .spikes(spikes)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] b_next(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return (s << 1) | 16'(fb);
  endfunction

  function automatic logic [7:0] b_draw(input logic [15:0] s, input int c);
    logic [15:0] r;
    int k;
    k = 2 * c;
    r = (k == 0) ? s : ((s << k) | (s >> (16 - k)));
    return r[15:8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_val(input int c, input logic [7:0] v);
    ld_en = 1; ld_idx = 2'(c); ld_val = v;
    @(negedge clk);
    ld_en = 0;
    m_val[c] = v;
  endtask

  task automatic load_seed(input logic [15:0] s);
    seed_ld = 1; seed_val = s;
    @(negedge clk);
    seed_ld = 0;
    m_rnd = (s == 0) ? 16'h0001 : s;
  endtask

  // one step, optionally with start, then a quiet cycle
  task automatic do_step(input logic st, input string req);
    logic [NCH-1:0] exp;
    exp = '0;
    if (st) begin
      m_cnt = 0;
      m_fired = '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (mode) begin
          if (m_val[c] != 0 && !m_fired[c] && m_cnt == 255 - int'(m_val[c])) begin
            exp[c] = 1'b1;
            m_fired[c] = 1'b1;
          end
        end else begin
          exp[c] = (b_draw(m_rnd, c) < m_val[c]);
        end
      end
      if (m_cnt < 256) m_cnt++;
    end
    step = 1; start = st;
    @(negedge clk);
    step = 0; start = 0;
    m_rnd = b_next(m_rnd);
    check(req, 32'(spikes), 32'(exp));
    for (int c = 0; c < NCH; c++) begin
      if (spikes[c]) begin
        if (n_fire[c] == 0) first_at[c] = m_cnt - 1;
        n_fire[c]++;
      end
    end
    @(negedge clk);
    check("R7 quiet cycle", 32'(spikes), 32'h0);
  endtask

  task automatic clear_stats();
    for (int c = 0; c < NCH; c++) begin
      first_at[c] = -1;
      n_fire[c] = 0;
    end
  endtask

  initial begin
    m_rnd = 16'hACE1;
    m_cnt = 0;
    m_fired = '0;
    for (int c = 0; c < NCH; c++) m_val[c] = 0;
    clear_stats();

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 spikes after reset", 32'(spikes), 32'h0);
    // R1: zero values give no rate spikes, seed default tracked by model
    mode = 0;
    for (int i = 0; i < 4; i++) do_step(0, "R1 default seed rate");

    // R8 / R2 / R4: load values and run rate mode
    load_val(0, 8'd0);
    load_val(1, 8'd255);
    load_val(2, 8'd128);
    load_val(3, 8'd37);
    clear_stats();
    for (int i = 0; i < 300; i++) do_step(0, "R2 rate compare");
    check("R4 zero value rate count", 32'(n_fire[0]), 32'd0);

    // R3: zero seed replaced by one, then a new seed
    load_seed(16'h0000);
    for (int i = 0; i < 40; i++) do_step(0, "R3 seed zero");
    load_seed(16'h1234);
    for (int i = 0; i < 40; i++) do_step(0, "R3 seed 1234");
    // R3: seed load wins over a step in the same cycle
    seed_ld = 1; seed_val = 16'hBEEF; step = 1;
    @(negedge clk);
    seed_ld = 0; step = 0;
    m_rnd = 16'hBEEF;
    @(negedge clk);
    for (int i = 0; i < 10; i++) do_step(0, "R3 seed priority");

    // R5: latency mode, one presentation
    mode = 1;
    load_val(0, 8'd255);
    load_val(1, 8'd200);
    load_val(2, 8'd1);
    load_val(3, 8'd0);
    do_step(1, "R6 start");
    clear_stats();
    for (int i = 0; i < 260; i++) do_step(0, "R5 latency vector");
    check("R5 ch0 first step", 32'(first_at[0]), 32'd0);
    check("R5 ch1 first step", 32'(first_at[1]), 32'd55);
    check("R5 ch2 first step", 32'(first_at[2]), 32'd254);
    check("R5 ch0 once", 32'(n_fire[0]), 32'd1);
    check("R5 ch1 once", 32'(n_fire[1]), 32'd1);
    check("R5 ch2 once", 32'(n_fire[2]), 32'd1);
    check("R4 zero value latency", 32'(n_fire[3]), 32'd0);

    // R6: restart mid-presentation; R8: reload one channel
    do_step(1, "R6 start");
    clear_stats();
    for (int i = 0; i < 30; i++) do_step(0, "R6 partial");
    load_val(3, 8'd240);
    do_step(1, "R6 restart");
    clear_stats();
    for (int i = 0; i < 60; i++) do_step(0, "R8 after reload");
    check("R6 ch0 refires at 0", 32'(first_at[0]), 32'd0);
    check("R8 ch3 new value slot", 32'(first_at[3]), 32'd15);
    check("R8 ch1 unchanged slot", 32'(first_at[1]), 32'd55);

    // R9: full-period spike counts in rate mode
    mode = 0;
    load_val(0, 8'd100);
    load_val(1, 8'd0);
    load_val(2, 8'd255);
    load_val(3, 8'd1);
    load_seed(16'h5A5A);
    clear_stats();
    step = 1;
    for (int i = 0; i < 65535; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) if (spikes[c]) n_fire[c]++;
    end
    step = 0;
    check("R9 v=100 count", 32'(n_fire[0]), 32'd25599);
    check("R9 v=0 count", 32'(n_fire[1]), 32'd0);
    check("R9 v=255 count", 32'(n_fire[2]), 32'd65279);
    check("R9 v=1 count", 32'(n_fire[3]), 32'd255);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule